// File: doc/BRIEF.md
# Even-Odd Pixel Offset Equalizer

This digital stage follows a 10-bit pixel converter whose samples come alternately from two sampling channels, even and odd. Each channel carries a slightly different residual offset. Inside the optical-black clamp window the stage keeps a separate running black-level estimate for each channel. Outside the window it uses those estimates to shift every pixel, so that both channels land on one programmed black reference.

A start-of-line pulse pins the channel assignment. The clamp strobe polarity comes from a 2-bit clock-mode field. A pixel-blank strobe zeroes the output. A bypass input routes the raw sample straight to the output, which is two cycles earlier than the corrected path.

Top module: `eo_offset_equalizer`

## Requirements
- R1: Input samples alternate between channel even (0) and odd (1) on every clock. A cycle with `line_start` high carries an even sample, and the following cycle is odd.
- R2: The clamp window is active when `clamp_in` equals `clk_mode[0]`. Modes 00 and 10 give an active-low strobe, and modes 01 and 11 give an active-high strobe. `clk_mode[1]` has no effect.
- R3: A channel's estimate changes only on a cycle whose sample belongs to that channel, with the clamp window active and `blank_n` high. A blanked pixel inside the window leaves both estimates unchanged.
- R4: The first accepted sample of a channel in each clamp window loads that channel's estimate with the sample value exactly. Leaving the window re-arms this seeding.
- R5: Each later accepted sample x updates the estimate e, which is held with 3 fractional bits, to e + floor((x - e) / 8).
- R6: A corrected pixel x equals x + T - int(e_ch). T is 32 for `clamp_lvl` 00, 48 for 01, 64 for 10 and 16 for 11. e_ch is the current estimate of the pixel's channel.
- R7: With `bypass` = 0, a pixel driven before clock edge k appears on `pix_out` after edge k+1. With `bypass` = 1, `pix_out` follows `sample_in` in the same cycle.
- R8: A pixel presented with `blank_n` low comes out as zero on both paths, with the same latency as that path.
- R9: The corrected value saturates to the range 0 to 1023.
- R10: Synchronous reset clears both estimates, their seeding state, the phase (next sample is even) and the output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Marks the current sample as even |
| sample_in | input | 10 | Converter sample |
| clamp_in | input | 1 | Optical-black clamp strobe |
| blank_n | input | 1 | Pixel blank, active low |
| clamp_lvl | input | 2 | Black reference select |
| clk_mode | input | 2 | Clamp polarity select (bit 0 used) |
| bypass | input | 1 | 1 bypasses correction |
| pix_out | output | 10 | Corrected pixel |

## Verification
Two functions can fall in the same cycle: black-level tracking in the clamp window and pixel blanking. The bench presents a blanked, out-of-range pixel as the first even sample of a window. It checks that this pixel comes out as zero two cycles later. It also checks that the next unblanked even sample, not the blanked one, seeds the estimate, by reading the corrected value of a pixel equal to that seed. A start-of-line pulse that lands on what would be an odd slot is judged the same way, through the corrected output of the channel it forces.

// File: rtl/eoq_pkg.sv
package eoq_pkg;
    localparam int unsigned DW   = 10;
    localparam int unsigned FRAC = 3;
    localparam int unsigned NCH  = 2;
    localparam int unsigned LVLW = 2;

    typedef logic [DW-1:0] pix_t;

    typedef struct packed {
        pix_t data;
        logic ch;
        logic vis;
    } stage_t;

    function automatic pix_t target_of(input logic [LVLW-1:0] code);
        pix_t t;
        unique case (code)
            2'b00:   t = pix_t'(32);
            2'b01:   t = pix_t'(48);
            2'b10:   t = pix_t'(64);
            default: t = pix_t'(16);
        endcase
        return t;
    endfunction

    function automatic pix_t clip(input logic signed [DW+1:0] v);
        if (v < 0)
            return '0;
        else if (v > $signed({2'b00, {DW{1'b1}}}))
            return '1;
        else
            return v[DW-1:0];
    endfunction
endpackage

// File: rtl/eoq_phase.sv
module eoq_phase (
    input  logic clk,
    input  logic rst,
    input  logic sol,
    output logic ch
);
    logic phase_q;

    assign ch = sol ? 1'b0 : phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~ch;
    end

    // R1: without a line start the channel flips every cycle
    a_r1_alternate: assert property (@(posedge clk) disable iff (rst)
        (!sol && !$past(rst)) |-> (ch != $past(ch)));
endmodule

// File: rtl/eoq_tracker.sv
module eoq_tracker #(
    parameter int unsigned W = eoq_pkg::DW,
    parameter int unsigned F = eoq_pkg::FRAC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         win,
    input  logic         upd,
    input  logic [W-1:0] sample,
    output logic [W-1:0] est
);
    localparam int unsigned AW = W + F;

    logic [AW-1:0]        acc_q;
    logic                 seeded_q;
    logic signed [AW+1:0] diff;
    logic signed [AW+1:0] step;
    logic signed [AW+1:0] sum;
    logic [AW-1:0]        acc_d;

    always_comb begin
        diff  = $signed({2'b00, sample, {F{1'b0}}}) - $signed({2'b00, acc_q});
        step  = diff >>> F;
        sum   = $signed({2'b00, acc_q}) + step;
        acc_d = seeded_q ? sum[AW-1:0] : {sample, {F{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            seeded_q <= 1'b0;
        end else begin
            if (!win)     seeded_q <= 1'b0;
            else if (upd) seeded_q <= 1'b1;
            if (upd)      acc_q <= acc_d;
        end
    end

    assign est = acc_q[AW-1:F];

    // R3: estimate holds when no accepted sample arrives
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(acc_q));

    // R4: first accepted sample in a window loads the estimate directly
    a_r4_seed: assert property (@(posedge clk) disable iff (rst)
        (upd && !seeded_q) |=> (acc_q == $past({sample, {F{1'b0}}})));
endmodule

// File: rtl/eoq_outstage.sv
module eoq_outstage
    import eoq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  stage_t          st_d,
    input  pix_t            est [NCH],
    input  logic [LVLW-1:0] lvl,
    output pix_t            out
);
    stage_t                st_q;
    pix_t                  out_q;
    pix_t                  est_sel;
    logic signed [DW+1:0]  sum;

    always_comb begin
        est_sel = est[st_q.ch];
        sum = $signed({2'b00, st_q.data}) + $signed({2'b00, target_of(lvl)})
            - $signed({2'b00, est_sel});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            out_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= st_q.vis ? clip(sum) : '0;
        end
    end

    assign out = out_q;

    // R8: a blanked pixel in the stage register yields zero next cycle
    a_r8_blank_zero: assert property (@(posedge clk) disable iff (rst)
        !st_q.vis |=> (out_q == '0));
endmodule

// File: rtl/eo_offset_equalizer.sv
module eo_offset_equalizer
    import eoq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            line_start,
    input  logic [DW-1:0]   sample_in,
    input  logic            clamp_in,
    input  logic            blank_n,
    input  logic [LVLW-1:0] clamp_lvl,
    input  logic [1:0]      clk_mode,
    input  logic            bypass,
    output logic [DW-1:0]   pix_out
);
    logic   ch;
    logic   clamp_act;
    logic   unused_mode_hi;
    pix_t   est [NCH];
    stage_t st_d;
    pix_t   corr;

    assign unused_mode_hi = clk_mode[1];
    assign clamp_act      = (clamp_in == clk_mode[0]);

    eoq_phase u_phase (
        .clk (clk),
        .rst (rst),
        .sol (line_start),
        .ch  (ch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic upd;
        assign upd = clamp_act & blank_n & (ch == 1'(g));
        eoq_tracker #(.W(DW), .F(FRAC)) u_trk (
            .clk    (clk),
            .rst    (rst),
            .win    (clamp_act),
            .upd    (upd),
            .sample (sample_in),
            .est    (est[g])
        );
    end

    always_comb begin
        st_d.data = sample_in;
        st_d.ch   = ch;
        st_d.vis  = blank_n;
    end

    eoq_outstage u_out (
        .clk  (clk),
        .rst  (rst),
        .st_d (st_d),
        .est  (est),
        .lvl  (clamp_lvl),
        .out  (corr)
    );

    assign pix_out = bypass ? (blank_n ? sample_in : '0) : corr;
endmodule

// File: tb/tb_eo_offset_equalizer.sv
module tb_eo_offset_equalizer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic [9:0] sample_in = '0;
    logic       clamp_in = 1'b1;
    logic       blank_n = 1'b1;
    logic [1:0] clamp_lvl = 2'b00;
    logic [1:0] clk_mode = 2'b00;
    logic       bypass = 1'b0;
    logic [9:0] pix_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    eo_offset_equalizer dut (
        .clk(clk), .rst(rst), .line_start(line_start), .sample_in(sample_in),
        .clamp_in(clamp_in), .blank_n(blank_n), .clamp_lvl(clamp_lvl),
        .clk_mode(clk_mode), .bypass(bypass), .pix_out(pix_out)
    );

    // behavioural reference: estimates in eighths of an LSB
    int m_acc [2];
    int m_seed [2];
    int m_phase, s1_x, s1_ch, s1_vis, m_out;

    function automatic int tgt(input logic [1:0] c);
        case (c)
            2'b00: return 32;
            2'b01: return 48;
            2'b10: return 64;
            default: return 16;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc[0] = 0; m_acc[1] = 0; m_seed[0] = 0; m_seed[1] = 0;
            m_phase = 0; s1_x = 0; s1_ch = 0; s1_vis = 0; m_out = 0;
        end else begin
            int ch, v;
            bit act;
            act = clk_mode[0] ? clamp_in : !clamp_in;
            ch  = line_start ? 0 : m_phase;
            v = s1_x + tgt(clamp_lvl) - (m_acc[s1_ch] / 8);
            if (v < 0) v = 0;
            if (v > 1023) v = 1023;
            m_out = s1_vis ? v : 0;
            if (!act) begin
                m_seed[0] = 0; m_seed[1] = 0;
            end else if (blank_n) begin
                if (m_seed[ch] == 0) begin
                    m_acc[ch] = int'(sample_in) * 8;
                    m_seed[ch] = 1;
                end else begin
                    m_acc[ch] = m_acc[ch] + ((int'(sample_in) * 8 - m_acc[ch]) >>> 3);
                end
            end
            s1_x = int'(sample_in); s1_ch = ch; s1_vis = blank_n;
            m_phase = 1 - ch;
        end
    end

    task automatic check(input int exp, input string tag);
        n_tests++;
        if (int'(pix_out) != exp) begin
            n_fail++;
            $display("FAIL %s: pix_out=%0d expected=%0d at %0t", tag, pix_out, exp, $time);
        end
    endtask

    // drive one pixel, then compare against the model
    task automatic step(input int x, input bit s, input bit c, input bit b, input string tag);
        int exp;
        @(negedge clk);
        sample_in = 10'(x); line_start = s; clamp_in = c; blank_n = b;
        #1;
        exp = bypass ? (b ? x : 0) : m_out;
        check(exp, tag);
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        // R10: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R10");
        rst = 1'b0;
        step(7, 0, 1, 1, "R10");
        check(0, "R10");

        // R4/R1: window seeds even 100, odd 120
        step(100, 1, 0, 1, "R1");
        for (int i = 1; i < 24; i++) step((i % 2) ? 120 : 100, 0, 0, 1, "R4");
        step(100, 1, 1, 1, "R6");
        step(120, 0, 1, 1, "R6");
        step(100, 0, 1, 1, "R6"); check(32, "R6 even");
        step(120, 0, 1, 1, "R6"); check(32, "R6 odd");

        // R6: other target code
        clamp_lvl = 2'b11;
        step(100, 1, 1, 1, "R6");
        step(120, 0, 1, 1, "R6");
        step(0, 0, 1, 1, "R6"); check(16, "R6 lvl11 even");
        step(0, 0, 1, 1, "R6"); check(16, "R6 lvl11 odd");
        clamp_lvl = 2'b00;

        // R9: low saturation
        step(50, 1, 1, 1, "R9");
        step(120, 0, 1, 1, "R9");
        step(0, 0, 1, 1, "R9"); check(0, "R9 low");

        // R1: line start on an odd slot forces even
        step(100, 1, 1, 1, "R1");
        step(100, 1, 1, 1, "R1");
        step(0, 0, 1, 1, "R1"); check(32, "R1 first");
        step(0, 0, 1, 1, "R1"); check(32, "R1 forced even");

        // R5: leaky update 100->110, 120->110
        step(100, 1, 0, 1, "R5");
        step(120, 0, 0, 1, "R5");
        step(180, 0, 0, 1, "R5");
        step(40, 0, 0, 1, "R5");
        step(110, 1, 1, 1, "R5");
        step(110, 0, 1, 1, "R5");
        step(0, 0, 1, 1, "R5"); check(32, "R5 even");
        step(0, 0, 1, 1, "R5"); check(32, "R5 odd");

        // R2: active-high mode ignores a low strobe
        clk_mode = 2'b01;
        step(300, 1, 0, 1, "R2");
        step(300, 0, 0, 1, "R2");
        step(110, 1, 0, 1, "R2");
        step(110, 0, 0, 1, "R2");
        step(0, 0, 0, 1, "R2"); check(32, "R2 low ignored");
        step(200, 1, 1, 1, "R2");
        step(200, 0, 1, 1, "R2");
        step(200, 1, 0, 1, "R2");
        step(200, 0, 0, 1, "R2");
        step(0, 0, 0, 1, "R2"); check(32, "R2 high even");
        step(0, 0, 0, 1, "R2"); check(32, "R2 high odd");
        clk_mode = 2'b10;
        step(100, 1, 0, 1, "R2");
        step(100, 0, 0, 1, "R2");
        step(100, 1, 1, 1, "R2");
        step(100, 0, 1, 1, "R2");
        step(0, 0, 1, 1, "R2"); check(32, "R2 mode10 even");
        clk_mode = 2'b00;

        // R3/R8: blanked pixel inside the window
        step(500, 1, 0, 0, "R3");
        step(90, 0, 0, 1, "R3");
        step(90, 0, 0, 1, "R8"); check(0, "R8 blanked");
        step(90, 0, 0, 1, "R3");
        step(90, 1, 1, 1, "R3");
        step(90, 0, 1, 1, "R3");
        step(0, 0, 1, 1, "R3"); check(32, "R3 even");
        step(0, 0, 1, 1, "R3"); check(32, "R3 odd");

        // R7: bypass and latency
        bypass = 1'b1;
        step(555, 1, 1, 1, "R7"); check(555, "R7 bypass");
        step(77, 0, 1, 0, "R8"); check(0, "R8 bypass blank");
        bypass = 1'b0;
        step(90, 1, 1, 1, "R7");
        step(300, 0, 1, 1, "R7");
        step(0, 0, 1, 1, "R7"); check(32, "R7 two cycles");

        // R9: high saturation
        clamp_lvl = 2'b10;
        step(5, 1, 0, 1, "R9");
        step(5, 0, 0, 1, "R9");
        step(1020, 1, 1, 1, "R9");
        step(1020, 0, 1, 1, "R9");
        step(0, 0, 1, 1, "R9"); check(1023, "R9 high");
        step(0, 0, 1, 1, "R9");

        report();
    end
endmodule